// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects interrupt events from six kinds of source and folds them into a single external interrupt request line. The sources are two PHY ports, each with a vector of event inputs that pass through a per-port mask, six general purpose input pins, each with its own status and enable bits, a 16-bit down-counting general purpose timer, a software-raised interrupt, and a one-time device-ready indication that appears shortly after reset.

Every source owns one bit in a top-level status register and one bit in a top-level enable register. The output line asserts only while some source has both bits set and the master enable in the configuration register is on. A polarity bit can invert the line. Software reaches all registers through a simple single-cycle write strobe, with read data driven combinationally from the address.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, every status, enable, mask and configuration bit is 0, the timer count and preload are 0xFFFF, and irq_o is 0.
- R2: irq_o equals (cfg master AND any(top status AND top enable)) XOR cfg invert, where the configuration register is at address 2 with master in bit 0 and invert in bit 1.
- R3: The top status register at address 0 holds PHY1 in bit 0, PHY2 in bit 1, GPIO in bit 2, timer in bit 3, software in bit 4 and ready in bit 5. The top enable register at address 1 uses the same bit positions. Writing 1 to a status bit clears it, writing 0 leaves it alone, and an event that arrives in the same cycle as a clear leaves the bit set.
- R4: Address 3 holds per-pin GPIO status in bits 5:0 (write 1 to clear) and per-pin enables in bits 13:8. A rising edge on gpio_i[n] sets status bit n at the third clock edge after the change, whether or not that pin is enabled.
- R5: Top bit 2 is the OR over the pins of (GPIO status AND GPIO enable), so it falls as soon as the underlying pin status bits are cleared or disabled.
- R6: The PHY1 and PHY2 masks are at addresses 4 and 5, bits 7:0. An event input sets its port's top status bit at the next edge only when its mask bit is 1. A masked event has no effect.
- R7: The timer enable is address 6 bit 0, the preload is address 7, and the live count reads at address 8. Writing the preload also loads the count. While the timer is enabled, the count drops by one per cycle. At zero it reloads from the preload and sets top bit 3. While the timer is disabled, the count holds.
- R8: Writing 1 to bit 4 of the top enable register sets the software status bit at the same edge.
- R9: The ready status bit sets exactly once, READY_DELAY cycles after reset is released, and it clears when 1 is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| gpio_i | input | 6 | Asynchronous GPIO pins |
| phy1_ev_i | input | 8 | PHY port 1 event inputs |
| phy2_ev_i | input | 8 | PHY port 2 event inputs |
| irq_o | output | 1 | Interrupt request line |

## Verification
Two functions can land in the same cycle: a write-1-to-clear on a status bit, and a fresh event on that same bit. The bench holds a PHY event input high while it writes the clear. It also drives pin edges and timer wraps into the same clock as writes to the GPIO and top status registers, both in directed steps and in a long pseudo-random run. A behavioural model judges every cycle and expects the set to win, so the bit must still read 1 after the edge. It also expects the irq line to follow the combined enables.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DW     = 16;
    localparam int AW     = 4;
    localparam int NSRC   = 6;
    localparam int NGPIO  = 6;
    localparam int NPHYEV = 8;
    localparam int TW     = 16;

    localparam int S_PHY1  = 0;
    localparam int S_PHY2  = 1;
    localparam int S_GPIO  = 2;
    localparam int S_TMR   = 3;
    localparam int S_SOFT  = 4;
    localparam int S_READY = 5;

    localparam int GEN_LSB = 8;

    typedef enum logic [AW-1:0] {
        A_TSTAT  = 4'd0,
        A_TEN    = 4'd1,
        A_CFG    = 4'd2,
        A_GPIO   = 4'd3,
        A_PMASK1 = 4'd4,
        A_PMASK2 = 4'd5,
        A_TCFG   = 4'd6,
        A_TPRE   = 4'd7,
        A_TCNT   = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic inv;
        logic master;
    } cfg_t;

    function automatic logic w1c_bit(input logic cur, input logic clr, input logic set);
        return (cur & ~clr) | set;
    endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= pin_i[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise_o[i] = s2 & ~s3;

        // R4: a detected edge lasts one cycle only
        a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
            rise_o[i] |=> !rise_o[i]);
    end
endmodule

// File: rtl/irq_gp_timer.sv
module irq_gp_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic [W-1:0] pre_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '1;
        else if (ld_i)
            cnt_q <= ld_val_i;
        else if (en_i)
            cnt_q <= (cnt_q == '0) ? pre_i : cnt_q - 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = en_i & ~ld_i & (cnt_q == '0);

    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        (en_i && !ld_i && cnt_q == '0) |=> cnt_q == $past(pre_i));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_ready_gen.sv
module irq_ready_gen #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    output logic pulse_o
);
    localparam int CW = $clog2(DELAY + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q != CW'(DELAY))
            cnt_q <= cnt_q + 1'b1;
    end

    assign pulse_o = (cnt_q == CW'(DELAY - 1));

    a_r9_once: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int READY_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NGPIO-1:0]  gpio_i,
    input  logic [NPHYEV-1:0] phy1_ev_i,
    input  logic [NPHYEV-1:0] phy2_ev_i,
    output logic              irq_o
);
    logic [NSRC-1:0]   st_q, top_st, src_set, src_clr, top_en_q;
    cfg_t              cfg_q;
    logic [NGPIO-1:0]  gst_q, gen_q, gpio_rise, gclr;
    logic [NPHYEV-1:0] mask1_q, mask2_q;
    logic              ten_q, tmr_wrap, rdy_pulse;
    logic [TW-1:0]     pre_q, tcnt;

    logic wr_tstat, wr_ten, wr_cfg, wr_gpio, wr_m1, wr_m2, wr_tcfg, wr_tpre;
    assign wr_tstat = reg_wr && reg_addr == A_TSTAT;
    assign wr_ten   = reg_wr && reg_addr == A_TEN;
    assign wr_cfg   = reg_wr && reg_addr == A_CFG;
    assign wr_gpio  = reg_wr && reg_addr == A_GPIO;
    assign wr_m1    = reg_wr && reg_addr == A_PMASK1;
    assign wr_m2    = reg_wr && reg_addr == A_PMASK2;
    assign wr_tcfg  = reg_wr && reg_addr == A_TCFG;
    assign wr_tpre  = reg_wr && reg_addr == A_TPRE;

    irq_sync_edge #(.N(NGPIO)) u_sync (
        .clk(clk), .rst(rst), .pin_i(gpio_i), .rise_o(gpio_rise));

    irq_gp_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .en_i(ten_q), .ld_i(wr_tpre),
        .ld_val_i(reg_wdata[TW-1:0]), .pre_i(pre_q),
        .cnt_o(tcnt), .wrap_o(tmr_wrap));

    irq_ready_gen #(.DELAY(READY_DELAY)) u_rdy (
        .clk(clk), .rst(rst), .pulse_o(rdy_pulse));

    // event sources for latched top-level bits
    always_comb begin
        src_set          = '0;
        src_set[S_PHY1]  = |(phy1_ev_i & mask1_q);
        src_set[S_PHY2]  = |(phy2_ev_i & mask2_q);
        src_set[S_TMR]   = tmr_wrap;
        src_set[S_SOFT]  = wr_ten & reg_wdata[S_SOFT];
        src_set[S_READY] = rdy_pulse;
        src_clr          = wr_tstat ? reg_wdata[NSRC-1:0] : '0;
        gclr             = wr_gpio ? reg_wdata[NGPIO-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            gst_q    <= '0;
            top_en_q <= '0;
            cfg_q    <= '0;
            gen_q    <= '0;
            mask1_q  <= '0;
            mask2_q  <= '0;
            ten_q    <= 1'b0;
            pre_q    <= '1;
        end else begin
            for (int i = 0; i < NSRC; i++)
                st_q[i] <= (i == S_GPIO) ? 1'b0 : w1c_bit(st_q[i], src_clr[i], src_set[i]);
            for (int i = 0; i < NGPIO; i++)
                gst_q[i] <= w1c_bit(gst_q[i], gclr[i], gpio_rise[i]);
            if (wr_ten)  top_en_q <= reg_wdata[NSRC-1:0];
            if (wr_cfg)  cfg_q    <= cfg_t'(reg_wdata[1:0]);
            if (wr_gpio) gen_q    <= reg_wdata[GEN_LSB +: NGPIO];
            if (wr_m1)   mask1_q  <= reg_wdata[NPHYEV-1:0];
            if (wr_m2)   mask2_q  <= reg_wdata[NPHYEV-1:0];
            if (wr_tcfg) ten_q    <= reg_wdata[0];
            if (wr_tpre) pre_q    <= reg_wdata[TW-1:0];
        end
    end

    always_comb begin
        top_st         = st_q;
        top_st[S_GPIO] = |(gst_q & gen_q);
    end

    assign irq_o = (cfg_q.master & |(top_st & top_en_q)) ^ cfg_q.inv;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_TSTAT:  reg_rdata[NSRC-1:0]   = top_st;
            A_TEN:    reg_rdata[NSRC-1:0]   = top_en_q;
            A_CFG:    reg_rdata[1:0]        = cfg_q;
            A_GPIO: begin
                reg_rdata[NGPIO-1:0]         = gst_q;
                reg_rdata[GEN_LSB +: NGPIO]  = gen_q;
            end
            A_PMASK1: reg_rdata[NPHYEV-1:0] = mask1_q;
            A_PMASK2: reg_rdata[NPHYEV-1:0] = mask2_q;
            A_TCFG:   reg_rdata[0]          = ten_q;
            A_TPRE:   reg_rdata[TW-1:0]     = pre_q;
            A_TCNT:   reg_rdata[TW-1:0]     = tcnt;
            default:  reg_rdata             = '0;
        endcase
    end

    a_r2_master_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.master |-> irq_o == cfg_q.inv);
    a_r3_no_clear_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_tstat |=> ((st_q & $past(st_q)) == $past(st_q)));
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        (src_set[S_PHY1] && src_clr[S_PHY1]) |=> st_q[S_PHY1]);
    a_r4_rise_sets: assert property (@(posedge clk) disable iff (rst)
        (gpio_rise != '0) |=> ((gst_q & $past(gpio_rise)) == $past(gpio_rise)));
    a_r8_soft_raise: assert property (@(posedge clk) disable iff (rst)
        src_set[S_SOFT] |=> top_st[S_SOFT]);
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    localparam int RDLY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [5:0]  gpio_i = '0;
    logic [7:0]  phy1_ev_i = '0, phy2_ev_i = '0;
    logic        irq_o;

    irq_aggregator #(.READY_DELAY(RDLY)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_i(gpio_i),
        .phy1_ev_i(phy1_ev_i), .phy2_ev_i(phy2_ev_i), .irq_o(irq_o));

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    string tag = "R1";
    bit done = 0;

    // reference model state
    bit [5:0]  m_st, m_en, m_gst, m_gen;
    bit [1:0]  m_cfg;
    bit [7:0]  m_mk1, m_mk2;
    bit        m_ten;
    bit [15:0] m_pre, m_cnt;
    bit [5:0]  m_p1, m_p2, m_p3;
    int        m_rc;

    function automatic bit [5:0] m_top();
        bit [5:0] t = m_st;
        t[2] = |(m_gst & m_gen);
        return t;
    endfunction

    function automatic bit [15:0] m_read(input bit [3:0] a);
        case (a)
            0: return {10'd0, m_top()};
            1: return {10'd0, m_en};
            2: return {14'd0, m_cfg};
            3: return {2'd0, m_gen, 2'd0, m_gst};
            4: return {8'd0, m_mk1};
            5: return {8'd0, m_mk2};
            6: return {15'd0, m_ten};
            7: return m_pre;
            8: return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    task automatic model_step();
        bit [5:0] rise, set, clr, gclr;
        bit wrap;
        if (rst) begin
            m_st = 0; m_en = 0; m_gst = 0; m_gen = 0; m_cfg = 0;
            m_mk1 = 0; m_mk2 = 0; m_ten = 0; m_pre = 16'hFFFF; m_cnt = 16'hFFFF;
            m_p1 = 0; m_p2 = 0; m_p3 = 0; m_rc = 0;
            return;
        end
        rise = m_p2 & ~m_p3;
        m_p3 = m_p2; m_p2 = m_p1; m_p1 = gpio_i;
        wrap = m_ten && m_cnt == 0 && !(reg_wr && reg_addr == 7);
        set = 0;
        set[0] = |(phy1_ev_i & m_mk1);
        set[1] = |(phy2_ev_i & m_mk2);
        set[3] = wrap;
        set[4] = reg_wr && reg_addr == 1 && reg_wdata[4];
        set[5] = (m_rc == RDLY - 1);
        if (m_rc < RDLY) m_rc++;
        clr  = (reg_wr && reg_addr == 0) ? reg_wdata[5:0] : 6'd0;
        gclr = (reg_wr && reg_addr == 3) ? reg_wdata[5:0] : 6'd0;
        m_st  = ((m_st & ~clr) | set) & 6'b111011;
        m_gst = (m_gst & ~gclr) | rise;
        if (reg_wr && reg_addr == 7) m_cnt = reg_wdata;
        else if (m_ten) m_cnt = (m_cnt == 0) ? m_pre : m_cnt - 16'd1;
        if (reg_wr) case (reg_addr)
            1: m_en  = reg_wdata[5:0];
            2: m_cfg = reg_wdata[1:0];
            3: m_gen = reg_wdata[13:8];
            4: m_mk1 = reg_wdata[7:0];
            5: m_mk2 = reg_wdata[7:0];
            6: m_ten = reg_wdata[0];
            7: m_pre = reg_wdata;
            default: ;
        endcase
    endtask

    task automatic tick();
        bit exp_irq;
        bit [15:0] exp_rd;
        model_step();
        @(posedge clk);
        #1;
        exp_irq = (m_cfg[0] & |(m_top() & m_en)) ^ m_cfg[1];
        exp_rd  = m_read(reg_addr);
        checks++;
        if (irq_o !== exp_irq) begin
            errors++;
            $display("FAIL %s irq_o actual=%b expected=%b t=%0t", tag, irq_o, exp_irq, $time);
        end
        checks++;
        if (reg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata[%0d] actual=%h expected=%h t=%0t", tag, reg_addr, reg_rdata, exp_rd, $time);
        end
    endtask

    task automatic idle(input int n, input bit [3:0] a);
        reg_wr = 0; reg_addr = a;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input bit [3:0] a, input bit [15:0] d, input bit [3:0] ra);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0; reg_addr = ra;
        tick();
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit [31:0] lf = 32'h1234_5678;
        rst = 1;
        idle(3, 0);
        rst = 0;
        // R1: every register after reset (ready still pending)
        tag = "R1";
        for (int a = 0; a < 3; a++) idle(1, 4'(a));
        // R9: ready appears after the delay, then W1C
        tag = "R9";
        idle(3, 0);
        wr(0, 16'h0020, 0);
        tag = "R1";
        for (int a = 3; a <= 8; a++) idle(1, 4'(a));
        // R6 masked vs unmasked; R2 master enable
        tag = "R6";
        wr(1, 16'h002F, 0);
        wr(4, 16'h0001, 0);
        wr(2, 16'h0001, 0);
        phy1_ev_i = 8'h02; idle(2, 0); phy1_ev_i = 0; idle(1, 0);
        phy1_ev_i = 8'h01; idle(1, 0); phy1_ev_i = 0; idle(1, 0);
        // R3: write 0 no effect, write 1 clears, set beats clear
        tag = "R3";
        wr(0, 16'h0000, 0);
        phy1_ev_i = 8'h01; wr(0, 16'h0001, 0); phy1_ev_i = 0;
        wr(0, 16'h0001, 0);
        // R2: polarity and master
        tag = "R2";
        wr(5, 16'h0080, 0);
        phy2_ev_i = 8'h80; idle(1, 0); phy2_ev_i = 0;
        wr(2, 16'h0003, 0);
        wr(2, 16'h0002, 0);
        wr(2, 16'h0001, 0);
        wr(0, 16'h0002, 0);
        // R4 / R5: GPIO edges, enables, auto-clearing top bit
        tag = "R4";
        wr(3, 16'h0500, 3);
        gpio_i = 6'b000101; idle(4, 3);
        gpio_i = 6'b000111; idle(4, 0);
        tag = "R5";
        wr(3, 16'h0501, 0);
        wr(3, 16'h0504, 0);
        tag = "R4";
        gpio_i = 0; idle(4, 3);
        wr(3, 16'h0002, 3);
        // R7: timer
        tag = "R7";
        wr(7, 16'd5, 8);
        idle(3, 8);
        wr(6, 16'h0001, 8);
        idle(14, 8);
        idle(2, 0);
        wr(6, 16'h0000, 8);
        idle(3, 8);
        wr(0, 16'h0008, 0);
        // R8: software interrupt
        tag = "R8";
        wr(1, 16'h0010, 0);
        wr(0, 16'h0010, 0);
        // mixed pseudo-random traffic, set/clear collisions
        tag = "R3";
        wr(7, 16'd3, 0);
        wr(6, 16'h0001, 0);
        wr(4, 16'h00FF, 0);
        for (int i = 0; i < 600; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            reg_wr    = lf[0] & lf[1];
            reg_addr  = 4'(lf[5:2] % 9);
            reg_wdata = (reg_addr == 7) ? {12'd0, lf[11:8]} : lf[31:16];
            gpio_i    = lf[14] ? lf[20:15] : gpio_i;
            phy1_ev_i = lf[22] ? lf[30:23] : 8'h00;
            phy2_ev_i = lf[6]  ? lf[29:22] : 8'h00;
            tick();
        end
        reg_wr = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule